// File: doc/BRIEF.md
# Data Lane Deskew Controller

This block is the per-lane control logic of a source-synchronous receiver's skew calibration. It moves one data lane's edges onto the rising edge of the forwarded clock by stepping a 32-tap data delay line. The tap is chosen by a one-hot select word. The analog side supplies a sampling strobe and a one-bit phase-detector result. The strobe fires only when a data rising edge arrives while the clock is low. Because the strobe comes from arbitrary data and not from a periodic toggle pattern, strobes are sparse and irregular. The controller therefore paces its work by counting strobes, not clock cycles.

A calibration begins with a synchronous start pulse. If the clock is first seen high, the controller adds delay until it sees the clock low. It then adds delay until the detector result rises from 0 to 1, which marks edge alignment. The found code is then shifted by a fixed offset equal to the replica delay that widens the strobe. A done flag reports the result, together with error and saturation flags. The start pulse can be issued again at any time, for foreground or background recalibration.

Top module: `lane_deskew_ctrl`

## Requirements
- R1: After reset, `tap_sel_o` is 32'h0000_0001 (tap 0, with bit i selecting tap i) and done, error and saturation flags are low. The block stays idle, ignoring strobes, until a start pulse arrives. Exactly one bit of `tap_sel_o` is set at all times.
- R2: The detector sample is used only on every 8th strobe counted from the last start. It is ignored on the other strobes and on cycles without a strobe. A tap change appears in the cycle after the clock edge that captured that 8th strobe.
- R3: After start the block is in a seek-low phase. An evaluation sample of 1 raises the tap by one and stays in that phase. A sample of 0 raises the tap by one and enters the search phase.
- R4: In the search phase, a sample of 0 raises the tap by one. A sample of 1 sets the tap to the current tap plus ALPHA (default 2) and raises done.
- R5: If the current tap plus ALPHA exceeds 31, the final tap is 31 and the saturation flag rises together with done. An exact sum of 31 does not set the saturation flag.
- R6: An evaluation at tap 31 that would need a further increment, in either phase, raises done and error together and holds tap 31.
- R7: Start is synchronous. It returns the tap to 0, clears the strobe count and all flags, and re-enters seek-low. It wins over a strobe in the same cycle, and that strobe is not counted.
- R8: Once done is high, it stays high and the tap stays frozen regardless of strobes and samples, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous calibration start / restart |
| strobe_i | input | 1 | One-cycle pulse: data rising edge seen while clock low |
| pd_sample_i | input | 1 | Phase-detector result captured on the strobe |
| tap_sel_o | output | 32 | One-hot tap select for the data delay line |
| done_o | output | 1 | Final tap applied |
| err_o | output | 1 | Search ran off the end of the delay line |
| sat_o | output | 1 | Final offset was clipped at tap 31 |

## Verification
The cases that are hardest to reach from the ports are those at the end of the delay line: saturation of the offset sum, and failure to find any transition. Each needs more than thirty evaluations of eight strobes, with the detector answering in one fixed way for the whole run. The bench models the delay line and detector as a function of the tap index it reads from `tap_sel_o`. In that model, one tap range reads clock-high and the aligned edge sits at a chosen tap. Placing the edge beyond 31, or never letting the clock read low, steers the controller into those corners. Non-evaluation strobes carry the inverted sample, so any use of them would move the tap to the wrong place.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_SEEK_LOW = 2'd1,
        PH_SEARCH   = 2'd2,
        PH_DONE     = 2'd3
    } phase_e;
endpackage

// File: rtl/deskew_pacer.sv
module deskew_pacer #(
    parameter int EVAL_EVERY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic enable_i,
    input  logic strobe_i,
    output logic eval_o
);
    localparam int CNT_W = (EVAL_EVERY > 2) ? $clog2(EVAL_EVERY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EVAL_EVERY - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign eval_o = !clear_i && enable_i && strobe_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (enable_i && strobe_i)
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PACE_ONLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && !clear_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/deskew_fsm.sv
module deskew_fsm
    import deskew_pkg::*;
#(
    parameter int NUM_TAPS = 32,
    parameter int ALPHA    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        eval_i,
    input  logic                        sample_i,
    output logic [$clog2(NUM_TAPS)-1:0] code_o,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        err_o,
    output logic                        sat_o
);
    localparam int CODE_W = $clog2(NUM_TAPS);
    localparam int SUM_W  = CODE_W + 1;
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_TAPS - 1);

    typedef struct packed {
        phase_e              ph;
        logic [CODE_W-1:0]   code;
        logic                done;
        logic                err;
        logic                sat;
    } st_t;

    st_t st_d, st_q;
    logic [SUM_W-1:0] sum;

    assign sum = {1'b0, st_q.code} + SUM_W'(ALPHA);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.ph   = PH_SEEK_LOW;
            st_d.code = '0;
            st_d.done = 1'b0;
            st_d.err  = 1'b0;
            st_d.sat  = 1'b0;
        end else if (eval_i) begin
            unique case (st_q.ph)
                PH_SEEK_LOW: begin
                    if (st_q.code == MAX_CODE) begin
                        st_d.ph   = PH_DONE;
                        st_d.done = 1'b1;
                        st_d.err  = 1'b1;
                    end else begin
                        st_d.code = st_q.code + 1'b1;
                        if (!sample_i) st_d.ph = PH_SEARCH;
                    end
                end
                PH_SEARCH: begin
                    if (sample_i) begin
                        st_d.ph   = PH_DONE;
                        st_d.done = 1'b1;
                        if (sum > SUM_W'(MAX_CODE)) begin
                            st_d.code = MAX_CODE;
                            st_d.sat  = 1'b1;
                        end else begin
                            st_d.code = sum[CODE_W-1:0];
                        end
                    end else if (st_q.code == MAX_CODE) begin
                        st_d.ph   = PH_DONE;
                        st_d.done = 1'b1;
                        st_d.err  = 1'b1;
                    end else begin
                        st_d.code = st_q.code + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.code <= '0;
            st_q.done <= 1'b0;
            st_q.err  <= 1'b0;
            st_q.sat  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign busy_o = (st_q.ph == PH_SEEK_LOW) || (st_q.ph == PH_SEARCH);
    assign done_o = st_q.done;
    assign err_o  = st_q.err;
    assign sat_o  = st_q.sat;

    AST_ERR_HOLDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> (st_q.code == MAX_CODE) && st_q.done); // R6
    AST_SAT_HOLDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sat |-> (st_q.code == MAX_CODE) && st_q.done && !st_q.err); // R5
    AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !start_i) |=> st_q.done && $stable(st_q.code)); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.code == '0) && !st_q.done && (st_q.ph == PH_SEEK_LOW)); // R7
endmodule

// File: rtl/deskew_onehot.sv
module deskew_onehot #(
    parameter int NUM_TAPS = 32
) (
    input  logic [$clog2(NUM_TAPS)-1:0] code_i,
    output logic [NUM_TAPS-1:0]         sel_o
);
    localparam int CODE_W = $clog2(NUM_TAPS);

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign sel_o[i] = (code_i == CODE_W'(i));
    end
endmodule

// File: rtl/lane_deskew_ctrl.sv
module lane_deskew_ctrl #(
    parameter int NUM_TAPS   = 32,
    parameter int EVAL_EVERY = 8,
    parameter int ALPHA      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                strobe_i,
    input  logic                pd_sample_i,
    output logic [NUM_TAPS-1:0] tap_sel_o,
    output logic                done_o,
    output logic                err_o,
    output logic                sat_o
);
    localparam int CODE_W = $clog2(NUM_TAPS);

    logic              eval;
    logic              busy;
    logic [CODE_W-1:0] code;

    deskew_pacer #(.EVAL_EVERY(EVAL_EVERY)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .enable_i (busy),
        .strobe_i (strobe_i),
        .eval_o   (eval)
    );

    deskew_fsm #(.NUM_TAPS(NUM_TAPS), .ALPHA(ALPHA)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .eval_i   (eval),
        .sample_i (pd_sample_i),
        .code_o   (code),
        .busy_o   (busy),
        .done_o   (done_o),
        .err_o    (err_o),
        .sat_o    (sat_o)
    );

    deskew_onehot #(.NUM_TAPS(NUM_TAPS)) u_dec (
        .code_i (code),
        .sel_o  (tap_sel_o)
    );

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel_o) == 1); // R1
    AST_CODE_PACED: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !eval) |=> $stable(code)); // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy); // R8
endmodule

// File: tb/lane_deskew_ctrl_bench.sv
module lane_deskew_ctrl_bench;
    localparam int TAPS  = 32;
    localparam int ALPHA = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            strobe = 1'b0;
    logic            pd = 1'b0;
    logic [TAPS-1:0] tap;
    logic            done, err, sat;

    always #4 clk = ~clk;

    lane_deskew_ctrl u_lane_deskew_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .strobe_i(strobe),
        .pd_sample_i(pd), .tap_sel_o(tap), .done_o(done), .err_o(err), .sat_o(sat)
    );

    typedef struct {
        int    code;
        bit    done;
        bit    err;
        bit    sat;
        string req;
    } exp_t;

    exp_t sb_q[$];
    event ev_check;
    int   checks = 0;
    int   errors = 0;

    int m_code, m_cnt;
    bit m_done, m_err, m_sat, m_busy, m_search;
    int hi_end, edge_at;

    task automatic chk(bit ok, string req, string act, string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    function automatic int tap_idx(logic [TAPS-1:0] v);
        for (int i = 0; i < TAPS; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic bit pd_of(int t);
        if (t < 0) return 1'b0;
        return (t < hi_end) || (t >= edge_at);
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(ev_check);
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                chk(tap == (32'h1 << it.code) && done == it.done && err == it.err && sat == it.sat,
                    it.req,
                    $sformatf("tap=%h done=%0b err=%0b sat=%0b", tap, done, err, sat),
                    $sformatf("tap=%h done=%0b err=%0b sat=%0b", 32'h1 << it.code, it.done, it.err, it.sat));
            end
        end
    end

    task automatic push(string req);
        exp_t it;
        it.code = m_code; it.done = m_done; it.err = m_err; it.sat = m_sat; it.req = req;
        sb_q.push_back(it);
        -> ev_check;
    endtask

    task automatic model_eval(bit s);
        if (!m_search) begin
            if (m_code == TAPS - 1) begin m_done = 1; m_err = 1; end
            else begin m_code++; if (!s) m_search = 1; end
        end else if (s) begin
            if (m_code + ALPHA > TAPS - 1) begin m_code = TAPS - 1; m_sat = 1; end
            else m_code = m_code + ALPHA;
            m_done = 1;
        end else if (m_code == TAPS - 1) begin
            m_done = 1; m_err = 1;
        end else begin
            m_code++;
        end
        if (m_done) m_busy = 0;
    endtask

    task automatic strobe_once(string req);
        bit s, is_eval;
        repeat ($urandom_range(0, 2)) begin
            @(negedge clk);
            pd = 1'($urandom);
        end
        @(negedge clk);
        strobe  = 1'b1;
        is_eval = m_busy && (m_cnt == 7);
        s       = pd_of(tap_idx(tap));
        pd      = is_eval ? s : ~s;
        @(negedge clk);
        strobe = 1'b0;
        pd     = 1'($urandom);
        if (m_busy) begin
            if (is_eval) begin m_cnt = 0; model_eval(s); end
            else m_cnt++;
        end
        push(req);
    endtask

    task automatic model_start();
        m_code = 0; m_cnt = 0; m_done = 0; m_err = 0; m_sat = 0;
        m_busy = 1; m_search = 0;
    endtask

    task automatic do_start(string req, bit with_strobe);
        @(negedge clk);
        start  = 1'b1;
        strobe = with_strobe;
        pd     = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        strobe = 1'b0;
        model_start();
        push(req);
    endtask

    task automatic run_cal(int h, int t, string req, int exp_tap, bit exp_err, bit exp_sat);
        int guard;
        hi_end  = h;
        edge_at = t;
        do_start(req, 1'b0);
        guard = 0;
        while (m_busy && guard < 600) begin
            strobe_once(req);
            guard++;
        end
        @(negedge clk);
        chk(done && tap == (32'h1 << exp_tap) && err == exp_err && sat == exp_sat, req,
            $sformatf("tap=%0d done=%0b err=%0b sat=%0b", tap_idx(tap), done, err, sat),
            $sformatf("tap=%0d done=1 err=%0b sat=%0b", exp_tap, exp_err, exp_sat));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        hi_end = 0; edge_at = 10;
        m_code = 0; m_cnt = 0; m_done = 0; m_err = 0; m_sat = 0; m_busy = 0; m_search = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(tap == 32'h1 && !done && !err && !sat, "R1",
            $sformatf("tap=%h d=%0b e=%0b s=%0b", tap, done, err, sat), "tap=00000001 d=0 e=0 s=0");
        // R1: idle ignores strobes before any start
        repeat (10) strobe_once("R1");

        // R4: plain search, edge at 10 -> 12
        run_cal(0, 10, "R4", 12, 0, 0);
        // R8: frozen after done
        repeat (16) strobe_once("R8");
        // R3: initial clock-high region then search
        run_cal(5, 12, "R3", 14, 0, 0);
        run_cal(3, 4, "R3", 6, 0, 0);
        // R5: saturation and exact-fit boundary
        run_cal(0, 30, "R5", 31, 0, 1);
        run_cal(0, 29, "R5", 31, 0, 0);
        // R6: no transition found, in search and in seek-low
        run_cal(0, 99, "R6", 31, 1, 0);
        run_cal(99, 99, "R6", 31, 1, 0);
        repeat (9) strobe_once("R8");

        // R7 / R2: restart mid-run, strobe count cleared
        hi_end = 0; edge_at = 20;
        do_start("R7", 1'b0);
        repeat (13) strobe_once("R2");
        do_start("R7", 1'b1);
        repeat (7) strobe_once("R2");
        strobe_once("R2");
        chk(tap == 32'h2, "R2", $sformatf("tap=%h", tap), "tap=00000002");
        while (m_busy) strobe_once("R4");
        @(negedge clk);
        chk(done && tap == (32'h1 << 22), "R4", $sformatf("tap=%0d", tap_idx(tap)), "tap=22");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule